// File: doc/BRIEF.md
# NAND ECC Session Sequencer

This block runs one error-correction session on an 8-bit NAND data path. Software drives a small control word that carries a lock bit, an init strobe, a message-length select and an ECC-type field. After an accepted init, the sequencer watches a byte-wide data strobe and counts the message bytes. When the message is complete it latches a 13-byte parity value and raises a completion flag.

A direction input is sampled at init. In encode direction the session ends when the message is complete and the encode-done flag is set. In decode direction the 13 stored parity bytes follow the message on the same strobe and are compared with the freshly accumulated parity. A fixed error-search latency then runs, and after it the decode-done flag and an error indication are raised. The real BCH arithmetic is replaced by a placeholder accumulator: each parity byte is the XOR of the message bytes that fall in its lane.

Top module: `nand_ecc_seq`

## Requirements
- R1: A synchronous active-low reset sets `lock` to 1, clears `enc_done`, `dec_done` and `err_found`, zeroes `parity` and returns the sequencer to idle.
- R2: Control word fields are: bit 7 lock, bit 5 init, bit 4 length select, bits 3:2 ECC type. A control write always loads the lock bit. The init bit is honoured only when `lock` was already 0 before that write. An init with the lock set starts nothing and leaves the flags unchanged.
- R3: Init is also honoured only when the type field is 2'b01. Any other type leaves the sequencer idle, so strobes neither set a flag nor change `parity`.
- R4: An honoured init clears the byte counter, the accumulator, `enc_done` and `dec_done`. It captures the length select (0 = 512 bytes, 1 = 24 bytes) and `dec_sel` (1 = decode). `parity` keeps its previous value.
- R5: The message byte with index j is XORed into parity lane j mod 13. On the clock edge that accepts the last message byte, in either direction, `parity[8k+7:8k]` takes lane k. In encode direction `enc_done` (status bit 4) rises on that same edge and not earlier.
- R6: While `lock` is 1, strobes are neither counted nor accumulated. Counting resumes where it stopped once the lock is cleared.
- R7: In decode direction, the 13 accepted strobes after the message carry stored parity bytes 0 to 12 in order. A mismatch of any of them against its accumulated lane marks an error.
- R8: `dec_done` (status bit 6) rises exactly 372 clock edges after the edge that accepts the last parity byte. The other status bits are 0 apart from bit 4.
- R9: `err_found` is 1 only while `dec_done` is 1 and a mismatch was seen in the session.
- R10: Strobes after the message (encode) or after the parity bytes (decode), up to the next init, change neither the flags, `err_found` nor `parity`.
- R11: A strobe in the same cycle as an honoured init is discarded and is not counted as the first message byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Control word write enable |
| cfg_wdata | input | 8 | Control word (lock, init, length, type) |
| dec_sel | input | 1 | Direction sampled at init: 1 decode, 0 encode |
| dat_stb | input | 1 | One data byte transferred this cycle |
| dat_byte | input | 8 | Data byte |
| lock | output | 1 | Current lock bit |
| status | output | 8 | Bit 6 decode done, bit 4 encode done, others 0 |
| enc_done | output | 1 | Encode session complete |
| dec_done | output | 1 | Decode search complete |
| err_found | output | 1 | Error present, valid with dec_done |
| parity | output | 104 | Latched parity, lane k at bits 8k+7:8k |

## Verification
Two events can land in the same cycle: a control write that carries an honoured init, and a data strobe. The bench drives both on one edge. It then sends 23 more bytes and checks that `enc_done` is still low, then one more byte and checks that `enc_done` rises with the parity of only those 24 bytes. This proves the colliding byte was dropped. A second case is a lock write arriving while a message is partly counted. It is judged by the final parity, computed in the bench over only the accepted bytes.

// File: rtl/nand_ecc_pkg.sv
// Package: shared state type and control-word field positions for the
// NAND ECC session sequencer. Assumes an 8-bit control word.
package nand_ecc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_MSG,
        ST_PAR,
        ST_SRCH,
        ST_DONE
    } seq_state_t;

    localparam int unsigned CTL_LOCK_BIT = 7;
    localparam int unsigned CTL_INIT_BIT = 5;
    localparam int unsigned CTL_LEN_BIT  = 4;
    localparam int unsigned CTL_TYPE_LO  = 2;
    localparam logic [1:0]  ECC_TYPE_8B  = 2'b01;
endpackage

// File: rtl/nand_ecc_cfg.sv
// Control word decode: holds the lock bit, qualifies the init strobe
// (lock already clear and type 8-bit), and captures length and direction
// at an accepted init. Assumes one control write per cycle at most.
module nand_ecc_cfg
    import nand_ecc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_we,
    input  logic [7:0] cfg_wdata,
    input  logic       dec_sel,
    output logic       lock_q,
    output logic       init_go,
    output logic       short_q,
    output logic       dec_q
);
    logic unused_cfg_bits;
    assign unused_cfg_bits = ^{cfg_wdata[6], cfg_wdata[1:0]};

    // Init is accepted only with the lock already clear and the 8-bit type.
    assign init_go = cfg_we && cfg_wdata[CTL_INIT_BIT] && !lock_q
                     && (cfg_wdata[CTL_TYPE_LO +: 2] == ECC_TYPE_8B);

    // Lock register: set by reset, loaded by every control write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_q <= 1'b1;
        end else if (cfg_we) begin
            lock_q <= cfg_wdata[CTL_LOCK_BIT];
        end
    end

    // Session mode capture at accepted init.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            short_q <= 1'b0;
            dec_q   <= 1'b0;
        end else if (init_go) begin
            short_q <= cfg_wdata[CTL_LEN_BIT];
            dec_q   <= dec_sel;
        end
    end
endmodule

// File: rtl/nand_ecc_fsm.sv
// Session sequencer: counts message bytes, then parity bytes in decode
// direction, then runs the fixed search latency. Produces the strobes for
// the accumulator and the two done flags. Assumes init_go outranks strobes.
module nand_ecc_fsm
    import nand_ecc_pkg::*;
#(
    parameter int MSG_LONG   = 512,
    parameter int MSG_SHORT  = 24,
    parameter int PAR_BYTES  = 13,
    parameter int SEARCH_CYC = 372,
    parameter int LANE_W     = $clog2(PAR_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init_go,
    input  logic              lock,
    input  logic              short_sel,
    input  logic              dec_mode,
    input  logic              dat_stb,
    output logic              acc_en,
    output logic              cmp_en,
    output logic              latch_en,
    output logic [LANE_W-1:0] lane,
    output logic              enc_done,
    output logic              dec_done,
    output logic              srch_active
);
    localparam int CNT_W = $clog2(MSG_LONG);
    localparam int TMR_W = $clog2(SEARCH_CYC);
    localparam logic [CNT_W-1:0]  LONG_LAST  = CNT_W'(MSG_LONG - 1);
    localparam logic [CNT_W-1:0]  SHORT_LAST = CNT_W'(MSG_SHORT - 1);
    localparam logic [LANE_W-1:0] LANE_LAST  = LANE_W'(PAR_BYTES - 1);
    localparam logic [TMR_W-1:0]  TMR_LAST   = TMR_W'(SEARCH_CYC - 1);

    seq_state_t       state_q;
    logic [CNT_W-1:0] cnt_q;
    logic [TMR_W-1:0] tmr_q;
    logic             stb_ok;
    logic             msg_last;

    // A strobe counts only when unlocked and not colliding with init.
    assign stb_ok      = dat_stb && !lock && !init_go;
    assign msg_last    = cnt_q == (short_sel ? SHORT_LAST : LONG_LAST);
    assign acc_en      = (state_q == ST_MSG) && stb_ok;
    assign latch_en    = acc_en && msg_last;
    assign cmp_en      = (state_q == ST_PAR) && stb_ok;
    assign srch_active = state_q == ST_SRCH;

    // Session state, byte and lane counters, search timer and done flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            cnt_q    <= '0;
            lane     <= '0;
            tmr_q    <= '0;
            enc_done <= 1'b0;
            dec_done <= 1'b0;
        end else if (init_go) begin
            state_q  <= ST_MSG;
            cnt_q    <= '0;
            lane     <= '0;
            tmr_q    <= '0;
            enc_done <= 1'b0;
            dec_done <= 1'b0;
        end else begin
            unique case (state_q)
                ST_MSG: begin
                    if (acc_en) begin
                        if (msg_last) begin
                            cnt_q    <= '0;
                            lane     <= '0;
                            state_q  <= dec_mode ? ST_PAR : ST_DONE;
                            enc_done <= !dec_mode;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                            lane  <= (lane == LANE_LAST) ? '0 : lane + 1'b1;
                        end
                    end
                end
                ST_PAR: begin
                    if (cmp_en) begin
                        if (lane == LANE_LAST) begin
                            lane    <= '0;
                            tmr_q   <= '0;
                            state_q <= ST_SRCH;
                        end else begin
                            lane <= lane + 1'b1;
                        end
                    end
                end
                ST_SRCH: begin
                    if (tmr_q == TMR_LAST) begin
                        state_q  <= ST_DONE;
                        dec_done <= 1'b1;
                    end else begin
                        tmr_q <= tmr_q + 1'b1;
                    end
                end
                default: begin
                    state_q <= state_q;
                end
            endcase
        end
    end
endmodule

// File: rtl/nand_ecc_acc.sv
// Placeholder parity engine: one XOR lane per parity byte, a parity
// register latched at message end, and a sticky mismatch flag set while
// stored parity bytes are compared. Assumes lane < PAR_BYTES.
module nand_ecc_acc #(
    parameter int PAR_BYTES = 13,
    parameter int LANE_W    = $clog2(PAR_BYTES)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clr,
    input  logic                   acc_en,
    input  logic                   cmp_en,
    input  logic                   latch_en,
    input  logic [LANE_W-1:0]      lane,
    input  logic [7:0]             dat_byte,
    output logic [8*PAR_BYTES-1:0] parity_q,
    output logic                   mismatch_q
);
    logic [7:0] acc_q   [PAR_BYTES];
    logic [7:0] acc_upd [PAR_BYTES];
    logic [7:0] lane_sel;

    for (genvar g = 0; g < PAR_BYTES; g++) begin : g_lane
        // Next value of this lane including the byte accepted this cycle.
        assign acc_upd[g] = (acc_en && lane == LANE_W'(g)) ? (acc_q[g] ^ dat_byte) : acc_q[g];

        // Lane accumulator, cleared at init.
        always_ff @(posedge clk) begin
            if (!rst_n || clr) begin
                acc_q[g] <= '0;
            end else begin
                acc_q[g] <= acc_upd[g];
            end
        end

        // Parity register for this lane, loaded at message end.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                parity_q[8*g +: 8] <= '0;
            end else if (latch_en) begin
                parity_q[8*g +: 8] <= acc_upd[g];
            end
        end
    end

    // Pick the accumulated lane that the incoming stored byte is checked against.
    always_comb begin
        lane_sel = '0;
        for (int i = 0; i < PAR_BYTES; i++) begin
            if (lane == LANE_W'(i)) begin
                lane_sel = acc_q[i];
            end
        end
    end

    // Sticky mismatch flag over the stored parity bytes.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            mismatch_q <= 1'b0;
        end else if (cmp_en && (dat_byte != lane_sel)) begin
            mismatch_q <= 1'b1;
        end
    end
endmodule

// File: rtl/nand_ecc_seq.sv
// Top of the NAND ECC session sequencer: control decode, session FSM and
// placeholder parity engine. Assumes a single clock with synchronous reset.
module nand_ecc_seq #(
    parameter int MSG_LONG   = 512,
    parameter int MSG_SHORT  = 24,
    parameter int PAR_BYTES  = 13,
    parameter int SEARCH_CYC = 372
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_we,
    input  logic [7:0]             cfg_wdata,
    input  logic                   dec_sel,
    input  logic                   dat_stb,
    input  logic [7:0]             dat_byte,
    output logic                   lock,
    output logic [7:0]             status,
    output logic                   enc_done,
    output logic                   dec_done,
    output logic                   err_found,
    output logic [8*PAR_BYTES-1:0] parity
);
    localparam int LANE_W = $clog2(PAR_BYTES);

    logic              init_go;
    logic              short_q;
    logic              dec_q;
    logic              acc_en;
    logic              cmp_en;
    logic              latch_en;
    logic [LANE_W-1:0] lane;
    logic              mismatch;
    logic              srch_active;

    nand_ecc_cfg u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .dec_sel   (dec_sel),
        .lock_q    (lock),
        .init_go   (init_go),
        .short_q   (short_q),
        .dec_q     (dec_q)
    );

    nand_ecc_fsm #(
        .MSG_LONG   (MSG_LONG),
        .MSG_SHORT  (MSG_SHORT),
        .PAR_BYTES  (PAR_BYTES),
        .SEARCH_CYC (SEARCH_CYC),
        .LANE_W     (LANE_W)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .init_go     (init_go),
        .lock        (lock),
        .short_sel   (short_q),
        .dec_mode    (dec_q),
        .dat_stb     (dat_stb),
        .acc_en      (acc_en),
        .cmp_en      (cmp_en),
        .latch_en    (latch_en),
        .lane        (lane),
        .enc_done    (enc_done),
        .dec_done    (dec_done),
        .srch_active (srch_active)
    );

    nand_ecc_acc #(
        .PAR_BYTES (PAR_BYTES),
        .LANE_W    (LANE_W)
    ) u_acc (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (init_go),
        .acc_en     (acc_en),
        .cmp_en     (cmp_en),
        .latch_en   (latch_en),
        .lane       (lane),
        .dat_byte   (dat_byte),
        .parity_q   (parity),
        .mismatch_q (mismatch)
    );

    // Error indication is only meaningful once the search has finished.
    assign err_found = mismatch && dec_done;
    assign status    = {1'b0, dec_done, 1'b0, enc_done, 4'b0000};
endmodule

// File: rtl/nand_ecc_seq_chk.sv
// Property checker for nand_ecc_seq, attached by bind. Measures the search
// window with its own counter rather than a long delay.
module nand_ecc_seq_chk #(
    parameter int PAR_BYTES  = 13,
    parameter int SEARCH_CYC = 372
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   cfg_we,
    input logic                   cfg_init,
    input logic [1:0]             cfg_type,
    input logic                   lock,
    input logic                   dat_stb,
    input logic                   enc_done,
    input logic                   dec_done,
    input logic [8*PAR_BYTES-1:0] parity,
    input logic                   srch_active
);
    localparam int LEN_W = $clog2(SEARCH_CYC + 1) + 1;
    localparam logic [LEN_W-1:0] LEN_MAX = {LEN_W{1'b1}};

    logic [LEN_W-1:0] srch_len;

    // Count consecutive cycles spent in the search phase (saturating).
    always_ff @(posedge clk) begin
        if (!rst_n || !srch_active) begin
            srch_len <= '0;
        end else if (srch_len != LEN_MAX) begin
            srch_len <= srch_len + 1'b1;
        end
    end

    assert_reset_lock_R1: assert property (@(posedge clk)
        !rst_n |=> (lock && !enc_done && !dec_done));

    assert_locked_init_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_init && lock) |=> ($stable(enc_done) && $stable(parity)));

    assert_init_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_init && !lock && cfg_type == 2'b01) |=> (!enc_done && !dec_done));

    assert_done_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(enc_done && dec_done));

    assert_locked_strobe_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_stb && lock) |=> $stable(parity));

    assert_search_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dec_done) |-> (srch_len >= LEN_W'(SEARCH_CYC)));
endmodule

bind nand_ecc_seq nand_ecc_seq_chk #(
    .PAR_BYTES  (PAR_BYTES),
    .SEARCH_CYC (SEARCH_CYC)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_we      (cfg_we),
    .cfg_init    (cfg_wdata[5]),
    .cfg_type    (cfg_wdata[3:2]),
    .lock        (lock),
    .dat_stb     (dat_stb),
    .enc_done    (enc_done),
    .dec_done    (dec_done),
    .parity      (parity),
    .srch_active (srch_active)
);

// File: tb/test_nand_ecc_seq.sv
// Bench for nand_ecc_seq: sweeps encode/decode sessions of both lengths,
// every parity-byte corruption position and every ECC type value.
module test_nand_ecc_seq;
    localparam int PB = 13;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          cfg_we;
    logic [7:0]    cfg_wdata;
    logic          dec_sel;
    logic          dat_stb;
    logic [7:0]    dat_byte;
    logic          lock;
    logic [7:0]    status;
    logic          enc_done;
    logic          dec_done;
    logic          err_found;
    logic [8*PB-1:0] parity;

    int n_run  = 0;
    int n_fail = 0;
    logic [7:0] ep [PB];
    logic [8*PB-1:0] saved;

    always #10 clk = ~clk;

    nand_ecc_seq i_nand_ecc_seq (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .dec_sel(dec_sel), .dat_stb(dat_stb), .dat_byte(dat_byte),
        .lock(lock), .status(status), .enc_done(enc_done), .dec_done(dec_done),
        .err_found(err_found), .parity(parity)
    );

    function automatic logic [7:0] pat(int j, int seed);
        return 8'((j * 7) + (seed * 31) + (j >> 3) + 1);
    endfunction

    function automatic logic [8*PB-1:0] packp();
        logic [8*PB-1:0] r;
        for (int k = 0; k < PB; k++) r[8*k +: 8] = ep[k];
        return r;
    endfunction

    task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Control word: bit7 lock, bit5 init, bit4 short, bits3:2 type.
    task automatic wr_cfg(bit lk, bit ini, bit sh, logic [1:0] ty);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_wdata = {lk, 1'b0, ini, sh, ty, 2'b00};
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic push(logic [7:0] b);
        @(negedge clk);
        dat_stb = 1'b1;
        dat_byte = b;
        @(negedge clk);
        dat_stb = 1'b0;
    endtask

    task automatic clr_ep();
        for (int k = 0; k < PB; k++) ep[k] = 8'h00;
    endtask

    task automatic start_session(bit dec, bit sh);
        dec_sel = dec;
        wr_cfg(1'b0, 1'b1, sh, 2'b01);
        clr_ep();
    endtask

    task automatic send_range(int start, int n, int seed);
        for (int k = 0; k < n; k++) begin
            ep[(start + k) % PB] = ep[(start + k) % PB] ^ pat(start + k, seed);
            push(pat(start + k, seed));
        end
    endtask

    task automatic do_decode(bit sh, int seed, int bad);
        start_session(1'b1, sh);
        send_range(0, sh ? 24 : 512, seed);
        chk("R5 decode parity latch", parity, packp());
        for (int k = 0; k < PB; k++) begin
            push((k == bad) ? (ep[k] ^ 8'h5A) : ep[k]);
        end
        repeat (371) @(negedge clk);
        chk("R8 dec_done before 372 edges", dec_done, 1'b0);
        chk("R9 err hidden during search", err_found, 1'b0);
        @(negedge clk);
        chk("R8 dec_done at 372 edges", dec_done, 1'b1);
        chk("R8 status word decode", status, 8'h40);
        chk("R7 error result", err_found, (bad >= 0) ? 1'b1 : 1'b0);
        push(8'h11);
        push(8'hEE);
        chk("R10 decode done holds", dec_done, 1'b1);
        chk("R10 error holds", err_found, (bad >= 0) ? 1'b1 : 1'b0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; cfg_we = 1'b0; cfg_wdata = '0;
        dec_sel = 1'b0; dat_stb = 1'b0; dat_byte = '0;
        clr_ep();
        repeat (3) @(negedge clk);
        chk("R1 reset lock", lock, 1'b1);
        chk("R1 reset status", status, 8'h00);
        chk("R1 reset flags", {enc_done, dec_done, err_found}, 3'b000);
        chk("R1 reset parity", parity, '0);
        rst_n = 1'b1;

        // R2: init while locked is ignored.
        wr_cfg(1'b1, 1'b1, 1'b1, 2'b01);
        send_range(0, 24, 1);
        chk("R2 locked init no session", enc_done, 1'b0);
        chk("R2 locked init parity", parity, '0);

        // R3: every non-8-bit type leaves the sequencer idle.
        for (int t = 0; t < 4; t++) begin
            if (t != 1) begin
                wr_cfg(1'b0, 1'b0, 1'b1, 2'b01);
                wr_cfg(1'b0, 1'b1, 1'b1, 2'(t));
                send_range(0, 24, 2);
                chk($sformatf("R3 type %0d enc_done", t), enc_done, 1'b0);
                chk($sformatf("R3 type %0d parity", t), parity, '0);
            end
        end

        // R5: short encode, done exactly at the 24th byte.
        start_session(1'b0, 1'b1);
        send_range(0, 23, 3);
        chk("R5 not done at 23", enc_done, 1'b0);
        send_range(23, 1, 3);
        chk("R5 done at 24", enc_done, 1'b1);
        chk("R5 status encode", status, 8'h10);
        chk("R5 short parity", parity, packp());
        saved = parity;

        // R10: surplus strobes after encode are ignored.
        for (int k = 0; k < 5; k++) push(8'hC3);
        chk("R10 parity after surplus", parity, saved);
        chk("R10 enc_done after surplus", enc_done, 1'b1);

        // R4: init clears flags, keeps parity register.
        start_session(1'b0, 1'b1);
        chk("R4 init clears enc_done", enc_done, 1'b0);
        chk("R4 init keeps parity", parity, saved);

        // R6: lock mid-message freezes counting and accumulation.
        send_range(0, 10, 4);
        wr_cfg(1'b1, 1'b0, 1'b1, 2'b01);
        for (int k = 0; k < 20; k++) push(8'(k * 13 + 5));
        chk("R6 locked enc_done", enc_done, 1'b0);
        chk("R6 lock visible", lock, 1'b1);
        wr_cfg(1'b0, 1'b0, 1'b1, 2'b01);
        send_range(10, 13, 4);
        chk("R6 not done before resume end", enc_done, 1'b0);
        send_range(23, 1, 4);
        chk("R6 done after resume", enc_done, 1'b1);
        chk("R6 parity skips locked bytes", parity, packp());

        // R5: long encode.
        start_session(1'b0, 1'b0);
        send_range(0, 511, 5);
        chk("R5 long not done at 511", enc_done, 1'b0);
        send_range(511, 1, 5);
        chk("R5 long done", enc_done, 1'b1);
        chk("R5 long parity", parity, packp());

        // R11: strobe colliding with init is discarded.
        dec_sel = 1'b0;
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_wdata = {1'b0, 1'b0, 1'b1, 1'b1, 2'b01, 2'b00};
        dat_stb = 1'b1;
        dat_byte = 8'hAA;
        @(negedge clk);
        cfg_we = 1'b0;
        dat_stb = 1'b0;
        clr_ep();
        send_range(0, 23, 6);
        chk("R11 collided byte not counted", enc_done, 1'b0);
        send_range(23, 1, 6);
        chk("R11 done after 24 clean bytes", enc_done, 1'b1);
        chk("R11 parity excludes collided byte", parity, packp());

        // R7/R8/R9: decode, clean and with each parity byte corrupted.
        do_decode(1'b1, 7, -1);
        for (int k = 0; k < PB; k++) do_decode(1'b1, 8 + k, k);
        do_decode(1'b0, 30, -1);
        do_decode(1'b0, 31, 12);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule